// File: doc/BRIEF.md
# Cache Event Counter Bank

The block is a bank of four independent 32-bit event counters that watch a cache controller. The cache presents a vector of single-cycle event pulses, one line per request or hit type. Each counter has a control word holding a 5-bit event code, which picks one pulse line to accumulate. A code of zero parks the counter. The counter value lives in a data word that software reads at any time and may overwrite, typically with zero before a measurement starts.

Both words sit on a plain register port: an address, a write strobe, write data and combinational read data. No overflow indication exists. A counter that passes its maximum wraps to zero without notice, so software must read it often enough to see every wrap.

Top module: `evt_perf_monitor`

## Requirements
- R1: Four counters of 32 bits. Counter i has its control word at byte offset 0xA8 + 8*i and its data word at byte offset 0xAC + 8*i.
- R2: The event code sits in control bits [7:3]. A control read returns the stored code in bits [7:3] with every other bit zero, whatever was written to those other bits.
- R3: Event code to `evt_i` bit: 0x0D read request = bit 0, 0x0E writeback request = bit 1, 0x0F invalidate-and-write request = bit 2, 0x10 invalidate request = bit 3, 0x13 evict request = bit 4, 0x14 invalidate-and-write hit = bit 5, 0x15 invalidate hit = bit 6, 0x17 read hit = bit 7. A counter adds one at each clock edge where its selected bit is high.
- R4: Event code zero stops the counter, which holds its value.
- R5: A nonzero code that is not in the list of R3, including any code of 0x18 or above, counts nothing, and the counter holds its value.
- R6: A counter at 0xFFFFFFFF that counts once becomes 0, with no other effect.
- R7: A data-word write loads the written value. When that write and a counted event fall in the same cycle, the written value is stored and the event is lost.
- R8: A control write changes the selection from the next cycle on. An event in the cycle of the control write is counted against the old code.
- R9: A read of any offset outside the eight words of R1 returns zero. A write there changes no register.
- R10: Reset (rst_ni low, asynchronous) clears every control and data word to zero.
- R11: Counters are independent. Two counters on the same code both count. Writing one counter's words leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 12 | Register byte offset |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| evt_i | input | 8 | Single-cycle event pulses from the cache, mapped as in R3 |

## Verification
A counted event can land in the same cycle as a software write to that counter's data word, or in the same cycle as a write to its control word. The bench provokes both collisions on purpose. It clears or preloads a data word while the selected pulse is high. It also retargets a control word while the old selection's pulse is high. A behavioural model applies the write-wins rule and the old-code-this-cycle rule, and the design is compared to that model after every clock. A pulse vector from a shift register also drives many cycles in which the collisions arise by chance.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;
  localparam int unsigned NUM_CNT   = 4;
  localparam int unsigned CNT_W     = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned NUM_EVT   = 8;
  localparam int unsigned SEL_W     = 5;
  localparam int unsigned SEL_LSB   = 3;
  localparam int unsigned CTRL_BASE = 'hA8;
  localparam int unsigned DATA_BASE = 'hAC;
  localparam int unsigned STRIDE    = 8;

  localparam logic [SEL_W-1:0] EV_RD_REQ   = 5'h0D;
  localparam logic [SEL_W-1:0] EV_WB_REQ   = 5'h0E;
  localparam logic [SEL_W-1:0] EV_IWR_REQ  = 5'h0F;
  localparam logic [SEL_W-1:0] EV_INV_REQ  = 5'h10;
  localparam logic [SEL_W-1:0] EV_EVC_REQ  = 5'h13;
  localparam logic [SEL_W-1:0] EV_IWR_HIT  = 5'h14;
  localparam logic [SEL_W-1:0] EV_INV_HIT  = 5'h15;
  localparam logic [SEL_W-1:0] EV_RD_HIT   = 5'h17;
  localparam logic [SEL_W-1:0] EV_LIMIT    = 5'h18;
endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
  import evt_mon_pkg::*;
#(
  parameter int unsigned N_CNT = NUM_CNT,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic [AW-1:0]    addr_i,
  output logic [N_CNT-1:0] ctrl_hit_o,
  output logic [N_CNT-1:0] data_hit_o
);
  for (genvar i = 0; i < N_CNT; i++) begin : g_dec
    localparam logic [AW-1:0] CTRL_OFS = AW'(CTRL_BASE + STRIDE * i);
    localparam logic [AW-1:0] DATA_OFS = AW'(DATA_BASE + STRIDE * i);
    assign ctrl_hit_o[i] = (addr_i == CTRL_OFS);
    assign data_hit_o[i] = (addr_i == DATA_OFS);
  end
endmodule

// File: rtl/evt_select.sv
module evt_select
  import evt_mon_pkg::*;
#(
  parameter int unsigned N_EVT = NUM_EVT,
  parameter int unsigned SW    = SEL_W
) (
  input  logic [SW-1:0]    sel_i,
  input  logic [N_EVT-1:0] evt_i,
  output logic             hit_o
);
  localparam int unsigned IDX_W = $clog2(N_EVT);

  logic [IDX_W-1:0] idx;
  logic             valid;

  always_comb begin
    valid = 1'b1;
    idx   = '0;
    unique case (sel_i)
      EV_RD_REQ:  idx = IDX_W'(0);
      EV_WB_REQ:  idx = IDX_W'(1);
      EV_IWR_REQ: idx = IDX_W'(2);
      EV_INV_REQ: idx = IDX_W'(3);
      EV_EVC_REQ: idx = IDX_W'(4);
      EV_IWR_HIT: idx = IDX_W'(5);
      EV_INV_HIT: idx = IDX_W'(6);
      EV_RD_HIT:  idx = IDX_W'(7);
      default:    valid = 1'b0;   // zero, holes and codes past the limit
    endcase
  end

  assign hit_o = valid && evt_i[idx];
endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_mon_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          data_we_i,
  input  logic [SW-1:0] sel_wdata_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          hit_i,
  output logic [SW-1:0] sel_o,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= '0;
    else if (ctrl_we_i) sel_o <= sel_wdata_i;
  end

  // software write beats the increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (data_we_i) cnt_o <= cnt_wdata_i;
    else if (hit_i)     cnt_o <= cnt_o + 1'b1;
  end

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> cnt_o == $past(cnt_wdata_i)); // R7
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_we_i && hit_i) |=> cnt_o == $past(cnt_o) + 1'b1); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_we_i && !hit_i) |=> $stable(cnt_o)); // R4
  AST_SEL_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0) |-> !hit_i); // R4
  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> sel_o == $past(sel_wdata_i)); // R8
endmodule

// File: rtl/evt_perf_monitor.sv
module evt_perf_monitor
  import evt_mon_pkg::*;
#(
  parameter int unsigned N_CNT = NUM_CNT,
  parameter int unsigned CW    = CNT_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned N_EVT = NUM_EVT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_we_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic [N_EVT-1:0] evt_i
);
  logic [N_CNT-1:0] ctrl_hit, data_hit, hit;
  logic [SEL_W-1:0] sel [N_CNT];
  logic [CW-1:0]    cnt [N_CNT];

  evt_reg_decode #(.N_CNT(N_CNT), .AW(AW)) u_dec (
    .addr_i     (reg_addr_i),
    .ctrl_hit_o (ctrl_hit),
    .data_hit_o (data_hit)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    evt_select #(.N_EVT(N_EVT), .SW(SEL_W)) u_sel (
      .sel_i (sel[i]),
      .evt_i (evt_i),
      .hit_o (hit[i])
    );

    evt_counter #(.CW(CW), .SW(SEL_W)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctrl_we_i   (reg_we_i && ctrl_hit[i]),
      .data_we_i   (reg_we_i && data_hit[i]),
      .sel_wdata_i (reg_wdata_i[SEL_LSB +: SEL_W]),
      .cnt_wdata_i (reg_wdata_i[CW-1:0]),
      .hit_i       (hit[i]),
      .sel_o       (sel[i]),
      .cnt_o       (cnt[i])
    );

    AST_BAD_CODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel[i] >= EV_LIMIT) |-> !hit[i]); // R5
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < N_CNT; i++) begin
      if (ctrl_hit[i]) reg_rdata_o[SEL_LSB +: SEL_W] = sel[i];
      if (data_hit[i]) reg_rdata_o = DW'(cnt[i]);
    end
  end

  AST_DECODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_hit, data_hit})); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ctrl_hit, data_hit} == '0) |-> reg_rdata_o == '0); // R9
endmodule

// File: tb/evt_perf_monitor_test.sv
module evt_perf_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [4:0]  m_code [4];
  logic [31:0] m_cnt  [4];

  always #2 clk = ~clk;

  evt_perf_monitor uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .evt_i       (evt)
  );

  function automatic int code_bit(input logic [4:0] c);
    case (c)
      5'h0D: return 0;
      5'h0E: return 1;
      5'h0F: return 2;
      5'h10: return 3;
      5'h13: return 4;
      5'h14: return 5;
      5'h15: return 6;
      5'h17: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    for (int i = 0; i < 4; i++) begin
      if (a == 12'(168 + 8 * i)) return {24'h0, m_code[i], 3'b000};
      if (a == 12'(172 + 8 * i)) return m_cnt[i];
    end
    return 32'h0;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 4; i++) begin
      m_code[i] = '0;
      m_cnt[i]  = '0;
    end
  endtask

  task automatic m_step(input logic [11:0] a, input logic w, input logic [31:0] d,
                        input logic [7:0] e);
    bit inc [4];
    for (int i = 0; i < 4; i++) begin
      int b = code_bit(m_code[i]);
      inc[i] = (b >= 0) && e[b];
    end
    for (int i = 0; i < 4; i++) begin
      if (w && a == 12'(168 + 8 * i)) m_code[i] = d[7:3];
      if (w && a == 12'(172 + 8 * i)) m_cnt[i] = d;
      else if (inc[i])                m_cnt[i] = m_cnt[i] + 32'd1;
    end
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                     input logic [7:0] e, input string tag);
    addr = a; we = w; wdata = d; evt = e;
    @(posedge clk);
    m_step(a, w, d, e);
    @(negedge clk);
    we = 1'b0; evt = '0;
    check(rdata, m_read(a), tag);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    addr = a; we = 1'b0; evt = '0;
    #1;
    check(rdata, m_read(a), tag);
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      rd(12'(168 + 8 * i), tag);
      rd(12'(172 + 8 * i), tag);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state, R9 unmapped reads
    rd_all("R10");
    rd(12'h0A0, "R9");
    rd(12'hFFC, "R9");

    // R2 control with junk outside [7:3]; R1 layout
    cyc(12'h0A8, 1'b1, 32'hFFFF_006F, 8'h00, "R2");
    cyc(12'h0B0, 1'b1, {24'h0, 5'h17, 3'b111}, 8'h00, "R2");
    cyc(12'h0B8, 1'b1, {24'hABCDEF, 5'h10, 3'b000}, 8'h00, "R2");
    cyc(12'h0C0, 1'b1, {24'h0, 5'h0D, 3'b000}, 8'h00, "R11");
    rd_all("R1");

    // R3 / R11 pseudo-random pulse traffic, every-clock compare
    for (int k = 0; k < 80; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(12'(172 + 8 * (k % 4)), 1'b0, 32'h0, lfsr, "R3");
    end
    rd_all("R11");

    // R7 data write collides with counted pulse
    cyc(12'h0AC, 1'b1, 32'h0000_1234, 8'h01, "R7");
    cyc(12'h0AC, 1'b0, 32'h0, 8'h01, "R7");
    cyc(12'h0AC, 1'b1, 32'h0, 8'hFF, "R7");
    rd(12'h0C4, "R11");

    // R6 wrap on counter 1 (read hit, bit 7)
    cyc(12'h0B4, 1'b1, 32'hFFFF_FFFE, 8'h00, "R6");
    cyc(12'h0B4, 1'b0, 32'h0, 8'h80, "R6");
    cyc(12'h0B4, 1'b0, 32'h0, 8'h80, "R6");
    cyc(12'h0B4, 1'b0, 32'h0, 8'h80, "R6");

    // R8 retarget counter 3 while old pulse is high
    cyc(12'h0C0, 1'b1, {24'h0, 5'h14, 3'b000}, 8'h01, "R8");
    cyc(12'h0C4, 1'b0, 32'h0, 8'h01, "R8");
    cyc(12'h0C4, 1'b0, 32'h0, 8'h20, "R8");

    // R4 code zero stops counter 0
    cyc(12'h0A8, 1'b1, 32'h0, 8'hFF, "R4");
    for (int k = 0; k < 4; k++) cyc(12'h0AC, 1'b0, 32'h0, 8'hFF, "R4");

    // R5 / R3 sweep every code on counter 2 with one-hot pulses
    for (int c = 0; c < 32; c++) begin
      cyc(12'h0B8, 1'b1, {24'h0, 5'(c), 3'b000}, 8'h00, "R5");
      cyc(12'h0BC, 1'b1, 32'h0, 8'h00, "R5");
      for (int b = 0; b < 8; b++) cyc(12'h0BC, 1'b0, 32'h0, 8'(1 << b), "R3");
      cyc(12'h0BC, 1'b0, 32'h0, 8'hFF, "R5");
    end

    // R9 writes to unmapped offsets change nothing
    cyc(12'h0A0, 1'b1, 32'hDEAD_BEEF, 8'h00, "R9");
    cyc(12'h0A9, 1'b1, 32'hDEAD_BEEF, 8'h00, "R9");
    cyc(12'h0C8, 1'b1, 32'hDEAD_BEEF, 8'h00, "R9");
    cyc(12'hFFC, 1'b1, 32'hDEAD_BEEF, 8'h00, "R9");
    rd_all("R9");

    // R10 reset mid-run
    cyc(12'h0B4, 1'b1, 32'h5555_AAAA, 8'h00, "R10");
    rst_n = 1'b0;
    m_clear();
    @(negedge clk);
    rd_all("R10");
    rst_n = 1'b1;
    @(negedge clk);
    rd_all("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule